// File: doc/BRIEF.md
# Receive Collision Statistics Counter

This block keeps a 16-bit running tally of the collisions that a network receiver reports. Each single-cycle pulse on the collision input adds one to the tally. The tally is presented at all times in the low half of a 32-bit read port. The upper half of that port is always zero. When the tally passes its maximum it wraps to zero and raises a sticky overflow flag. That flag belongs to a separate status register and is cleared by writing a one to it.

Software cannot load the tally. A write to the counter register is discarded in normal operation. When the test-mode input is high, the same write adds one to the tally, whatever the data. This lets a test program step the counter to any value, including the wrap point. Holding the stop input forces the tally to zero and blocks every increment. A hard reset or a soft reset clears both the tally and the overflow flag. Both resets are synchronous and active high.

Top module: `rx_coll_counter`

## Requirements
- R1: `reg_rdata` equals the tally zero-extended to 32 bits in every cycle, including while `stop` is high. Bits 31:16 are always 0.
- R2: Each clock edge with `coll_evt` high and `stop` low adds one to the tally. An event while the tally holds 65535 gives 0.
- R3: A clock edge with `reg_wr_en` high and `test_en` low leaves the tally unchanged, whatever the value of `reg_wdata`.
- R4: A clock edge with `reg_wr_en` and `test_en` both high and `stop` low adds exactly one to the tally, whatever the value of `reg_wdata`. `test_en` high without a write has no effect.
- R5: When a collision event and a test-mode write fall on the same edge, the tally advances by two, modulo 65536 (65534 gives 0).
- R6: On a clock edge with `stop` high, the tally becomes 0 and all increments on that edge are discarded. Counting resumes from 0 on the first edge with `stop` low.
- R7: A clock edge with `rst` high, or with `soft_rst` high, clears both the tally and `ovf_flag`.
- R8: `ovf_flag` goes high on the same edge that the tally wraps past 65535. It then stays high through any later counting.
- R9: A clock edge with `ovf_wr_en` high and `ovf_wr_bit` = 1 clears `ovf_flag`. With `ovf_wr_bit` = 0 the flag is unchanged.
- R10: `stop` has no effect on `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Forces the tally to zero and blocks counting |
| test_en | input | 1 | Test mode: register writes increment the tally |
| coll_evt | input | 1 | One-cycle pulse per collision seen by the receiver |
| reg_wr_en | input | 1 | Write strobe of the counter register |
| reg_wdata | input | 32 | Write data of the counter register (never loaded) |
| reg_rdata | output | 32 | Read data: tally in bits 15:0, zero above |
| ovf_wr_en | input | 1 | Write strobe of the status register holding the flag |
| ovf_wr_bit | input | 1 | Status write data for the flag; 1 clears it |
| ovf_flag | output | 1 | Sticky wrap indicator |

## Verification
The clocked properties assume that every input is a clean 0 or 1 at each rising edge. Each property checks only cycles after reset has been released. The properties for a given input case hold only when no other strobe is active on that edge. For example, the plain-write check assumes that no collision event and no stop arrive together with the write. The bench drives all inputs on the falling edge and applies one scenario at a time. It raises simultaneous strobes only in the cases that test the dual-increment and stop-priority rules.

// File: rtl/rx_coll_pkg.sv
package rx_coll_pkg;

    // Per-cycle request to the tally register
    typedef struct packed {
        logic [1:0] amount;     // 0, 1 or 2 increments this cycle
        logic       hold_zero;  // force the tally to zero
    } step_t;

    // Requested action on the sticky overflow flag
    typedef enum logic [1:0] {
        OVF_KEEP  = 2'd0,
        OVF_SET   = 2'd1,
        OVF_CLEAR = 2'd2
    } ovf_act_e;

    // Number of increment sources active in one cycle
    function automatic logic [1:0] step_amount(input logic evt, input logic test_wr);
        return {1'b0, evt} + {1'b0, test_wr};
    endfunction

endpackage

// File: rtl/rx_coll_step.sv
module rx_coll_step
    import rx_coll_pkg::*;
(
    input  logic  coll_evt,
    input  logic  reg_wr_en,
    input  logic  test_en,
    input  logic  stop,
    output step_t step
);

    logic test_wr;

    // In test mode, a write counts as an extra increment; otherwise it is dropped
    assign test_wr = reg_wr_en & test_en;

    always_comb begin
        step.hold_zero = stop;
        step.amount    = stop ? 2'd0 : step_amount(coll_evt, test_wr);
    end

endmodule

// File: rtl/rx_coll_count.sv
module rx_coll_count
    import rx_coll_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  step_t            step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] count_nxt;
    logic             past_ok;

    assign sum = {1'b0, count} + SUM_W'(step.amount);

    always_comb begin
        if (step.hold_zero) begin
            count_nxt = '0;
            wrap      = 1'b0;
        end else begin
            count_nxt = sum[CNT_W-1:0];
            wrap      = sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            count <= '0;
        end else begin
            count <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) past_ok <= 1'b0;
        else                 past_ok <= 1'b1;
    end

    // R2: a single increment from the maximum gives zero
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(step.amount == 2'd1 && !step.hold_zero && count == '1) |-> count == '0);

    // R5: a double increment advances by two, modulo the width
    assert_double_step_R5: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(step.amount == 2'd2 && !step.hold_zero) |-> count == $past(count) + CNT_W'(2));

    // R6: a stop cycle leaves the tally at zero
    assert_stop_zero_R6: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(step.hold_zero) |-> count == '0);

endmodule

// File: rtl/rx_coll_ovf.sv
module rx_coll_ovf
    import rx_coll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic wrap,
    input  logic clr_wr_en,
    input  logic clr_wr_bit,
    output logic flag
);

    ovf_act_e act;
    logic     past_ok;

    // A wrap on the same edge as a clear keeps the flag set
    always_comb begin
        if (wrap)                         act = OVF_SET;
        else if (clr_wr_en && clr_wr_bit) act = OVF_CLEAR;
        else                              act = OVF_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            flag <= 1'b0;
        end else begin
            unique case (act)
                OVF_SET:   flag <= 1'b1;
                OVF_CLEAR: flag <= 1'b0;
                default:   flag <= flag;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) past_ok <= 1'b0;
        else                 past_ok <= 1'b1;
    end

    // R8: a wrap raises the flag on the same edge
    assert_set_on_wrap_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(wrap) |-> flag);

    // R8: without a clear, the flag stays high
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(flag && !(clr_wr_en && clr_wr_bit)) |-> flag);

    // R9: a write of one clears the flag when no wrap competes
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(clr_wr_en && clr_wr_bit && !wrap) |-> !flag);

endmodule

// File: rtl/rx_coll_counter.sv
module rx_coll_counter
    import rx_coll_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             stop,
    input  logic             test_en,
    input  logic             coll_evt,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ovf_wr_en,
    input  logic             ovf_wr_bit,
    output logic             ovf_flag
);

    step_t            step;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             past_ok;
    logic             unused_wdata;

    // Written data is never stored
    assign unused_wdata = ^reg_wdata;

    rx_coll_step u_step (
        .coll_evt  (coll_evt),
        .reg_wr_en (reg_wr_en),
        .test_en   (test_en),
        .stop      (stop),
        .step      (step)
    );

    rx_coll_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .step     (step),
        .count    (count),
        .wrap     (wrap)
    );

    rx_coll_ovf u_ovf (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .wrap       (wrap),
        .clr_wr_en  (ovf_wr_en),
        .clr_wr_bit (ovf_wr_bit),
        .flag       (ovf_flag)
    );

    assign reg_rdata = REG_W'(count);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) past_ok <= 1'b0;
        else                 past_ok <= 1'b1;
    end

    // R3: a write outside test mode changes nothing
    assert_plain_write_R3: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(reg_wr_en && !test_en && !coll_evt && !stop)
        |-> reg_rdata == $past(reg_rdata));

    // R4: a test-mode write alone adds exactly one
    assert_test_write_R4: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(reg_wr_en && test_en && !coll_evt && !stop)
        |-> reg_rdata[CNT_W-1:0] == $past(reg_rdata[CNT_W-1:0]) + CNT_W'(1));

    // R10: stop leaves the overflow flag alone
    assert_stop_keeps_flag_R10: assert property (@(posedge clk) disable iff (rst || soft_rst)
        past_ok && $past(stop && !(ovf_wr_en && ovf_wr_bit)) |-> ovf_flag == $past(ovf_flag));

endmodule

// File: tb/rx_coll_counter_tb.sv
module rx_coll_counter_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        stop = 1'b0;
    logic        test_en = 1'b0;
    logic        coll_evt = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ovf_wr_en = 1'b0;
    logic        ovf_wr_bit = 1'b0;
    logic        ovf_flag;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_coll_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .stop       (stop),
        .test_en    (test_en),
        .coll_evt   (coll_evt),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ovf_wr_en  (ovf_wr_en),
        .ovf_wr_bit (ovf_wr_bit),
        .ovf_flag   (ovf_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs after a falling edge and hold them over the next rising edge
    task automatic cyc(input logic evt, input logic wr, input logic tst, input logic stp,
                       input logic owr, input logic obit, input logic [31:0] wd);
        coll_evt   = evt;
        reg_wr_en  = wr;
        test_en    = tst;
        stop       = stp;
        ovf_wr_en  = owr;
        ovf_wr_bit = obit;
        reg_wdata  = wd;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 32'h0);
    endtask

    task automatic fill_dual(input int n);
        for (int i = 0; i < n; i++) cyc(1, 1, 1, 0, 0, 0, 32'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle();
        idle();
        rst = 1'b0;
        check("R7 hard reset tally", reg_rdata, 32'h0);
        check("R7 hard reset flag", {31'b0, ovf_flag}, 32'h0);
    endtask

    task automatic t_events();
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        check("R2 three events", reg_rdata, 32'h3);
        idle();
        check("R1 idle read, upper zero", reg_rdata, 32'h3);
    endtask

    task automatic t_plain_write();
        cyc(0, 1, 0, 0, 0, 0, 32'hFFFF_FFFF);
        check("R3 write all ones ignored", reg_rdata, 32'h3);
        cyc(0, 1, 0, 0, 0, 0, 32'h0000_1234);
        check("R3 write pattern ignored", reg_rdata, 32'h3);
    endtask

    task automatic t_test_write();
        cyc(0, 1, 1, 0, 0, 0, 32'h0000_ABCD);
        check("R4 test write adds one", reg_rdata, 32'h4);
        cyc(0, 0, 1, 0, 0, 0, 32'h0);
        check("R4 test mode without write", reg_rdata, 32'h4);
    endtask

    task automatic t_dual();
        cyc(1, 1, 1, 0, 0, 0, 32'h5555_0000);
        check("R5 event plus test write", reg_rdata, 32'h6);
    endtask

    task automatic t_stop();
        cyc(1, 0, 0, 1, 0, 0, 32'h0);
        check("R6 stop clears", reg_rdata, 32'h0);
        for (int i = 0; i < 3; i++) begin
            cyc(1, 1, 1, 1, 0, 0, 32'h0);
            check("R6 R1 held at zero under stop", reg_rdata, 32'h0);
        end
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        check("R6 resume after stop", reg_rdata, 32'h1);
    endtask

    task automatic t_wrap();
        fill_dual(32767);
        check("R2 reach maximum", reg_rdata, 32'h0000_FFFF);
        check("R8 no flag before wrap", {31'b0, ovf_flag}, 32'h0);
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        check("R2 wrap to zero", reg_rdata, 32'h0);
        check("R8 flag on wrap", {31'b0, ovf_flag}, 32'h1);
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        check("R2 count after wrap", reg_rdata, 32'h1);
        check("R8 flag sticky", {31'b0, ovf_flag}, 32'h1);
    endtask

    task automatic t_ovf_clear();
        cyc(0, 0, 0, 0, 1, 0, 32'h0);
        check("R9 write zero keeps flag", {31'b0, ovf_flag}, 32'h1);
        cyc(0, 0, 0, 0, 1, 1, 32'h0);
        check("R9 write one clears flag", {31'b0, ovf_flag}, 32'h0);
        check("R9 tally untouched", reg_rdata, 32'h1);
    endtask

    task automatic t_dual_wrap();
        fill_dual(32766);
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        check("R5 reach 65534", reg_rdata, 32'h0000_FFFE);
        cyc(1, 1, 1, 0, 0, 0, 32'h0);
        check("R5 double step wraps to zero", reg_rdata, 32'h0);
        check("R8 flag on double wrap", {31'b0, ovf_flag}, 32'h1);
    endtask

    task automatic t_stop_flag();
        cyc(1, 0, 0, 1, 0, 0, 32'h0);
        check("R10 flag kept under stop", {31'b0, ovf_flag}, 32'h1);
        idle();
        check("R10 flag kept after stop", {31'b0, ovf_flag}, 32'h1);
    endtask

    task automatic t_soft();
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        check("R2 count before soft reset", reg_rdata, 32'h2);
        soft_rst = 1'b1;
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        soft_rst = 1'b0;
        check("R7 soft reset tally", reg_rdata, 32'h0);
        check("R7 soft reset flag", {31'b0, ovf_flag}, 32'h0);
    endtask

    task automatic t_hard();
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        check("R2 count before hard reset", reg_rdata, 32'h1);
        rst = 1'b1;
        cyc(1, 0, 0, 0, 0, 0, 32'h0);
        rst = 1'b0;
        check("R7 hard reset mid-run", reg_rdata, 32'h0);
        idle();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_events();
        t_plain_write();
        t_test_write();
        t_dual();
        t_stop();
        t_wrap();
        t_ovf_clear();
        t_dual_wrap();
        t_stop_flag();
        t_soft();
        t_hard();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule